// File: doc/BRIEF.md
# Burst Clock Generator with Enforced Idle Gaps

This block turns a free-running reference clock into a framed sideband clock. The output clock runs in bursts of exactly 64 full pulses, one pulse per reference period (one unit interval, UI). After each burst it is held low for an idle gap of a programmable number of UI, and then the next burst starts. A receiver samples data only on the edges inside a burst. The block drives a data-valid strobe that marks the burst cycles, and it emits a one-cycle pulse at the start of each burst and another at its end.

The gated clock is produced by AND-ing the reference clock with an enable that is registered on the falling reference edge. This is the behaviour of an integrated clock-gating cell, and it is modelled here in plain logic. The requested gap length is floored at 32 UI. The value is captured at reset and again at the close of every burst. Dropping the run enable never cuts a burst short: it only stops the next one from starting.

Top module: `burst_clk_gen`

## Requirements
- R1: Every burst has exactly 64 consecutive reference cycles with `data_valid` high, and `gclk` shows exactly 64 rising edges in that burst.
- R2: Between two bursts, `data_valid` stays low for exactly G reference cycles, where G = max(`gap_ui`, 32). `gap_ui` is captured at reset and in the last cycle of each burst. A change made during a gap does not take effect until the gap after the next burst.
- R3: A `gap_ui` value below 32 (including 0) gives a gap of exactly 32 cycles.
- R4: `gate_en` changes only on the falling edge of `clk_ref`. `gclk` equals `clk_ref` AND `gate_en`. During a burst, `gate_en` and `gclk` are high in the high phase of each valid cycle, and both are low in the gap.
- R5: `burst_start` is high for one cycle only, in the first valid cycle of each burst.
- R6: `burst_end` is high for one cycle only, in the first cycle after the 64th valid cycle.
- R7: While `enable` is low, no burst starts. Once the gap has elapsed, setting `enable` high before a rising edge gives one more low cycle, and then the burst begins.
- R8: Clearing `enable` during a burst does not shorten it. The burst completes all 64 cycles, and no further burst follows.
- R9: While `rst_n` is low, every output is low. After reset is released, the first burst begins only after G low cycles.
- R10: While `enable` stays high, bursts and gaps alternate without end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock; one period is one UI |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new bursts to start |
| gap_ui | input | GAP_W (8) | Requested idle gap in UI, floored at 32 |
| gclk | output | 1 | Gated burst clock |
| gate_en | output | 1 | Falling-edge-registered gating enable |
| data_valid | output | 1 | High in each burst cycle |
| burst_start | output | 1 | One-cycle pulse on the first burst cycle |
| burst_end | output | 1 | One-cycle pulse after the last burst cycle |

## Verification
The hardest case to reach is a change of `enable` or `gap_ui` at an awkward moment. Examples are clearing `enable` partway through a burst, or moving `gap_ui` after the value has already been captured for the current gap. The stimulus reaches these cases by counting valid cycles at the ports. It clears `enable` after the tenth valid cycle, writes a new gap value in the middle of a burst, and writes another value in the first gap cycle. It then measures the following gap length against the value captured at the end of the burst. A separate case holds `enable` low long after the gap has elapsed. It then checks that the burst starts after exactly one further cycle.

// File: rtl/burst_clk_pkg.sv
// Shared definitions for the burst clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_clk_pkg;
    typedef enum logic {
        PH_GAP   = 1'b0,
        PH_BURST = 1'b1
    } phase_e;
endpackage

// File: rtl/bcg_sequencer.sv
// Phase sequencer: counts burst cycles and gap cycles on the rising
// reference edge and raises run_en for exactly BURST_LEN cycles per burst.
// Assumes: MIN_GAP fits in GAP_W bits and MIN_GAP >= 2.
module bcg_sequencer
    import burst_clk_pkg::*;
#(
    parameter int BURST_LEN = 64,
    parameter int MIN_GAP   = 32,
    parameter int GAP_W     = 8
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [GAP_W-1:0] gap_ui,
    output logic             run_en
);
    localparam int BL_W  = $clog2(BURST_LEN);
    localparam int CNT_W = (BL_W > GAP_W) ? BL_W : GAP_W;

    phase_e             phase;
    logic [CNT_W-1:0]   cnt;
    logic [GAP_W-1:0]   gap_len;
    logic [GAP_W-1:0]   gap_eff;
    logic               gap_done;
    logic               burst_last;

    // Floor the requested gap at the minimum
    always_comb begin
        gap_eff = (gap_ui < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : gap_ui;
    end

    // Decode end-of-phase conditions from the shared counter
    always_comb begin
        gap_done   = (cnt >= (CNT_W'(gap_len) - CNT_W'(1)));
        burst_last = (cnt == CNT_W'(BURST_LEN - 1));
    end

    // Phase and counter update; gap length captured at reset and burst close
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            phase   <= PH_GAP;
            cnt     <= '0;
            gap_len <= gap_eff;
        end else begin
            case (phase)
                PH_GAP: begin
                    if (gap_done) begin
                        if (enable) begin
                            phase <= PH_BURST;
                            cnt   <= '0;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (burst_last) begin
                        phase   <= PH_GAP;
                        cnt     <= '0;
                        gap_len <= gap_eff;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    assign run_en = (phase == PH_BURST);

    // R3
    gap_floor_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        gap_len >= GAP_W'(MIN_GAP));

    // R7
    gap_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (phase == PH_GAP && !enable) |=> (phase == PH_GAP));

    // R8
    burst_keep_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (phase == PH_BURST && !enable && !burst_last) |=> (phase == PH_BURST));
endmodule

// File: rtl/bcg_gate.sv
// Clock gate model: captures run_en on the falling reference edge, as a
// latch-based gating cell would, and ANDs it with the reference clock.
// Assumes: run_en changes only just after rising edges of clk_ref.
module bcg_gate (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic run_en,
    output logic gate_en,
    output logic gclk
);
    logic gate_q;

    // Enable sampled while the reference clock is low, so no runt pulse
    always_ff @(negedge clk_ref) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= run_en;
        end
    end

    assign gate_en = gate_q;
    assign gclk    = clk_ref & gate_q;

    // R4
    gate_track_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        gate_en == run_en);
endmodule

// File: rtl/bcg_strobe.sv
// Strobe generator: data_valid one cycle behind run_en (aligned with gclk
// pulses), plus one-cycle start and end markers.
// Assumes: run_en is a registered signal in the clk_ref rising domain.
module bcg_strobe #(
    parameter int BURST_LEN = 64,
    parameter int MIN_GAP   = 32
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic run_en,
    output logic data_valid,
    output logic burst_start,
    output logic burst_end
);
    logic valid_q;
    logic start_q;
    logic end_q;

    // Register valid and edge markers from the sequencer output
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            start_q <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            valid_q <= run_en;
            start_q <= run_en & ~valid_q;
            end_q   <= ~run_en & valid_q;
        end
    end

    assign data_valid  = valid_q;
    assign burst_start = start_q;
    assign burst_end   = end_q;

    // Checker-only run-length counters for valid and idle stretches
    logic [15:0] hi_run;
    logic [15:0] lo_run;
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= valid_q ? hi_run + 16'd1 : 16'd0;
            lo_run <= valid_q ? 16'd0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1);
        end
    end

    // R1
    burst_len_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(data_valid) |-> (hi_run == 16'(BURST_LEN)));

    // R1
    burst_over_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        hi_run <= 16'(BURST_LEN));

    // R2
    gap_min_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(data_valid) |-> (lo_run >= 16'(MIN_GAP)));

    // R5
    start_edge_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        burst_start |-> (data_valid && !$past(data_valid)));

    // R6
    end_edge_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        burst_end |-> (!data_valid && $past(data_valid)));
endmodule

// File: rtl/burst_clk_gen.sv
// Top level: framed sideband clock of fixed-length bursts separated by a
// programmable, floored idle gap.
// Assumes: clk_ref is free-running; one period equals one UI.
module burst_clk_gen #(
    parameter int BURST_LEN = 64,
    parameter int MIN_GAP   = 32,
    parameter int GAP_W     = 8
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [GAP_W-1:0] gap_ui,
    output logic             gclk,
    output logic             gate_en,
    output logic             data_valid,
    output logic             burst_start,
    output logic             burst_end
);
    logic run_en;

    // Burst/gap phase sequencing
    bcg_sequencer #(
        .BURST_LEN (BURST_LEN),
        .MIN_GAP   (MIN_GAP),
        .GAP_W     (GAP_W)
    ) u_seq (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .enable  (enable),
        .gap_ui  (gap_ui),
        .run_en  (run_en)
    );

    // Glitch-free clock gating
    bcg_gate u_gate (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .gate_en (gate_en),
        .gclk    (gclk)
    );

    // Receiver-facing strobes
    bcg_strobe #(
        .BURST_LEN (BURST_LEN),
        .MIN_GAP   (MIN_GAP)
    ) u_strobe (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .data_valid  (data_valid),
        .burst_start (burst_start),
        .burst_end   (burst_end)
    );
endmodule

// File: tb/test_burst_clk_gen.sv
`timescale 1ns/1ps
module test_burst_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] gap_ui = 8'd32;
    logic       gclk, gate_en, data_valid, burst_start, burst_end;

    always #2 clk = ~clk;   // 250 MHz

    burst_clk_gen i_burst_clk_gen (
        .clk_ref     (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .gap_ui      (gap_ui),
        .gclk        (gclk),
        .gate_en     (gate_en),
        .data_valid  (data_valid),
        .burst_start (burst_start),
        .burst_end   (burst_end)
    );

    int pulses = 0;
    always @(posedge gclk) pulses++;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed { int gin; int gexp; } vec_t;
    localparam vec_t VECS [7] = '{
        '{32, 32}, '{40, 40}, '{5, 32}, '{0, 32},
        '{100, 100}, '{33, 33}, '{255, 255}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance one cycle and sample 1 ns after the rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input int g, input bit en);
        rst_n  = 1'b0;
        gap_ui = 8'(g);
        enable = en;
        repeat (3) tick();
        // R9: everything low in reset
        chk("R9", int'({data_valid, burst_start, burst_end, gate_en, gclk}), 0);
        rst_n = 1'b1;
    endtask

    // count low cycles from the current sample until data_valid rises
    task automatic count_low(output int n, output int ends);
        n = 0;
        ends = 0;
        while (!data_valid && n < 5000) begin
            if (n > 0 && burst_end) ends++;
            n++;
            tick();
        end
    endtask

    // measure a burst starting at its first valid sample
    task automatic meas_burst(input string tag);
        int p0, m, extra_start, mism;
        chk({tag, " R5 start"}, int'(burst_start), 1);
        p0 = pulses - 1;   // first rising edge of gclk already seen
        m = 0; extra_start = 0; mism = 0;
        while (data_valid && m < 5000) begin
            if (m > 0 && burst_start) extra_start++;
            if (gate_en !== 1'b1 || gclk !== 1'b1 || burst_end) mism++;
            m++;
            tick();
        end
        chk({tag, " R1 valid cycles"}, m, 64);
        chk({tag, " R1 gclk pulses"}, pulses - p0, 64);
        chk({tag, " R5 single start"}, extra_start, 0);
        chk({tag, " R4 gate high in burst"}, mism, 0);
        chk({tag, " R6 end pulse"}, int'(burst_end), 1);
        chk({tag, " R4 gate low in gap"}, int'({gate_en, gclk}), 0);
    endtask

    initial begin
        int n, ends, hi, p0;
        // table-driven gap lengths
        foreach (VECS[i]) begin
            do_reset(VECS[i].gin, 1'b1);
            tick();
            count_low(n, ends);
            chk((VECS[i].gin < 32) ? "R3 first gap" : "R9 first gap", n, VECS[i].gexp);
            meas_burst("burst1");
            count_low(n, ends);
            chk("R2 gap between bursts", n, VECS[i].gexp);
            chk("R6 single end", ends, 0);
            meas_burst("R10 burst2");
        end

        // R2: capture point of gap_ui
        do_reset(40, 1'b1);
        tick();
        count_low(n, ends);
        gap_ui = 8'd50;          // mid-burst: captured at burst close
        meas_burst("latch");
        gap_ui = 8'd100;         // first gap cycle: too late for this gap
        count_low(n, ends);
        chk("R2 captured gap", n, 50);
        meas_burst("latch2");
        count_low(n, ends);
        chk("R2 next gap uses later value", n, 100);

        // R7: enable low holds off bursts
        do_reset(32, 1'b0);
        tick();
        hi = 0; p0 = pulses;
        repeat (150) begin
            if (data_valid) hi++;
            tick();
        end
        chk("R7 no burst while disabled", hi, 0);
        chk("R7 no gclk while disabled", pulses - p0, 0);
        enable = 1'b1;
        tick();
        chk("R7 one idle cycle after enable", int'(data_valid), 0);
        tick();
        chk("R7 burst starts", int'(data_valid), 1);
        chk("R7 start pulse", int'(burst_start), 1);

        // R8: drop enable mid-burst
        hi = 0;
        while (data_valid && hi < 5000) begin
            hi++;
            if (hi == 10) enable = 1'b0;
            tick();
        end
        chk("R8 burst completes", hi, 64);
        chk("R8 end pulse", int'(burst_end), 1);
        hi = 0; p0 = pulses;
        repeat (200) begin
            if (data_valid) hi++;
            tick();
        end
        chk("R8 no further burst", hi, 0);
        chk("R8 no further gclk", pulses - p0, 0);

        // R9: reset in mid-burst clears outputs
        do_reset(32, 1'b1);
        tick();
        count_low(n, ends);
        repeat (5) tick();
        do_reset(32, 1'b1);
        tick();
        count_low(n, ends);
        chk("R9 gap after mid-burst reset", n, 32);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule